// File: doc/BRIEF.md
# Loadable Local Scan Clock Cycle Counter

This block lets a parked local scan port receive a precise number of test clock pulses, for example to let a device under test run its built-in self-test for a known number of cycles and then freeze. A down-counter, 32 bits wide by default, is loaded through a data-register scan while the counter-select instruction is current. It takes the scanned value when the TAP passes through Update-DR. Separate instruction strobes switch counting on and off.

While counting is switched on, every local clock pulse that passes through the gate lowers the count by one. When the count has reached zero and the port is parked, the local clock is held low. A status bit reports whether terminal count has been reached. The gate uses a latch that is transparent while the backplane clock is low, so the local clock never carries a runt pulse. A Capture-DR with counter-select current copies the live count into the scan register, so the count can also be read back. The TAP controller and instruction decoder are outside this block and supply decoded state and instruction levels.

Top module: `tck_cycle_counter`

## Requirements
- R1: After reset the count is zero, counting is switched off and the status bit reads 1.
- R2: While the select input is high, each rising clock edge with the shift-state input high shifts the scan register one place toward scan-out, taking in scan-in at the top and presenting bit 0 first. An Update-DR edge with select high copies the scan register into the count. A Capture-DR edge with select high copies the count into the scan register.
- R3: With counting switched on, exactly N local clock pulses follow a load of value N while the port is parked. The first pulse comes on the backplane rising edge that follows the Update-DR edge.
- R4: The status bit is 0 while the count is nonzero and 1 when the count is zero.
- R5: While counting is switched off, the local clock follows the backplane clock with no gating and the count does not change. The off strobe switches counting off and takes priority over a simultaneous on strobe.
- R6: While the port is not parked, the local clock is never gated, even at terminal count with counting switched on.
- R7: A clock edge with the Test-Logic-Reset input high clears the count and the scan register to zero and switches counting off.
- R8: Shift, capture and update edges have no effect on the scan register or the count while the select input is low.
- R9: The local clock is low whenever the backplane clock is low, and it changes only in step with the backplane clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Backplane test clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tlrState | input | 1 | TAP is in Test-Logic-Reset |
| captureDr | input | 1 | TAP is in Capture-DR |
| shiftDr | input | 1 | TAP is in Shift-DR |
| updateDr | input | 1 | TAP is in Update-DR |
| selActive | input | 1 | Counter-select instruction is current |
| cntOnStb | input | 1 | Counter-on instruction strobe |
| cntOffStb | input | 1 | Counter-off instruction strobe |
| tdi | input | 1 | Serial scan-in data |
| portParked | input | 1 | Local port is parked |
| localTck | output | 1 | Gated local test clock |
| tdo | output | 1 | Serial scan-out data (bit 0 of scan register) |
| termStatus | output | 1 | Terminal count reached |

## Verification
The hardest case to reach is the exact pulse count at the boundaries. A load of zero must produce no pulse at all. A load of one must produce a single pulse on the edge right after Update-DR. The last pulse must pass in full while the gate closes behind it. To get there, the bench builds the design with an 8-bit counter and sweeps every load value from 0 to 255 with counting on and the port parked. It counts rising edges of the local clock in a monitor and compares the total with the loaded value, and it checks separately that the Update-DR edge itself produces no pulse.

// File: rtl/tck_cnt_pkg.sv
`timescale 1ns/1ps
package tck_cnt_pkg;

  // Strobes from control to datapath, one per rising TCK edge.
  typedef struct packed {
    logic clear;    // Test-Logic-Reset clear
    logic shift;    // shift scan register
    logic capture;  // copy count into scan register
    logic load;     // copy scan register into count
    logic countEn;  // decrement allowed
  } cntStrobes_t;

endpackage

// File: rtl/tck_cnt_ctrl.sv
`timescale 1ns/1ps
module tck_cnt_ctrl
  import tck_cnt_pkg::*;
(
  input  logic        tck,
  input  logic        rstN,
  input  logic        tlrState,
  input  logic        captureDr,
  input  logic        shiftDr,
  input  logic        updateDr,
  input  logic        selActive,
  input  logic        cntOnStb,
  input  logic        cntOffStb,
  input  logic        portParked,
  input  logic        cntZero,
  output cntStrobes_t strobes,
  output logic        gateOff
);

  logic countOn;

  // Counting enable flag: reset and off win over on.
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)          countOn <= 1'b0;
    else if (tlrState)  countOn <= 1'b0;
    else if (cntOffStb) countOn <= 1'b0;
    else if (cntOnStb)  countOn <= 1'b1;
  end

  always_comb begin
    strobes.clear   = tlrState;
    strobes.shift   = selActive & shiftDr & ~tlrState;
    strobes.capture = selActive & captureDr & ~tlrState;
    strobes.load    = selActive & updateDr & ~tlrState;
    strobes.countEn = countOn;
  end

  // Gate request: counting on, terminal count, port parked.
  assign gateOff = countOn & cntZero & portParked;

  // R5: off strobe leaves counting switched off
  p_off_wins_r5: assert property (@(posedge tck) disable iff (!rstN)
    cntOffStb |=> !countOn);

  // R7: reset state switches counting off
  p_tlr_off_r7: assert property (@(posedge tck) disable iff (!rstN)
    tlrState |=> !countOn);

  // R5: on strobe alone switches counting on
  p_on_r5: assert property (@(posedge tck) disable iff (!rstN)
    (cntOnStb && !cntOffStb && !tlrState) |=> countOn);

endmodule

// File: rtl/tck_cnt_datapath.sv
`timescale 1ns/1ps
module tck_cnt_datapath
  import tck_cnt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             tck,
  input  logic             rstN,
  input  cntStrobes_t      strobes,
  input  logic             tdi,
  output logic             tdo,
  output logic             cntZero,
  output logic [WIDTH-1:0] countQ
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] scanQ;
  logic             decNow;

  assign cntZero = (countQ == ZERO);
  assign decNow  = strobes.countEn & ~cntZero;

  // Scan register: shift toward bit 0, capture the live count.
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                scanQ <= ZERO;
    else if (strobes.clear)   scanQ <= ZERO;
    else if (strobes.capture) scanQ <= countQ;
    else if (strobes.shift)   scanQ <= {tdi, scanQ[WIDTH-1:1]};
  end

  // Down-counter: one step per passed local pulse.
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)              countQ <= ZERO;
    else if (strobes.clear) countQ <= ZERO;
    else if (strobes.load)  countQ <= scanQ;
    else if (decNow)        countQ <= countQ - ONE;
  end

  assign tdo = scanQ[0];

  // R2: update copies the scan register
  p_load_r2: assert property (@(posedge tck) disable iff (!rstN)
    (strobes.load && !strobes.clear) |=> countQ == $past(scanQ));

  // R7: clear empties the count
  p_clear_r7: assert property (@(posedge tck) disable iff (!rstN)
    strobes.clear |=> countQ == ZERO);

  // R3: decrement by one per enabled edge
  p_dec_r3: assert property (@(posedge tck) disable iff (!rstN)
    (strobes.countEn && countQ != ZERO && !strobes.load && !strobes.clear)
      |=> countQ == $past(countQ) - ONE);

  // R5: count holds while counting is off
  p_hold_r5: assert property (@(posedge tck) disable iff (!rstN)
    (!strobes.countEn && !strobes.load && !strobes.clear) |=> $stable(countQ));

  // R3: the count never wraps below zero
  p_no_wrap_r3: assert property (@(posedge tck) disable iff (!rstN)
    (countQ == ZERO && !strobes.load) |=> countQ == ZERO);

endmodule

// File: rtl/tck_cnt_clk_gate.sv
`timescale 1ns/1ps
module tck_cnt_clk_gate (
  input  logic tck,
  input  logic gateOff,
  output logic localTck
);

  logic passQ;

  // Latch open while the clock is low, so the enable settles before the high phase.
  always_latch begin
    if (!tck) passQ = ~gateOff;
  end

  assign localTck = tck & passQ;

  // R9: local clock is low while backplane clock is low
  always_comb begin
    if (!tck) p_low_follow_r9: assert (localTck == 1'b0);
  end

endmodule

// File: rtl/tck_cycle_counter.sv
`timescale 1ns/1ps
module tck_cycle_counter
  import tck_cnt_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic tck,
  input  logic rstN,
  input  logic tlrState,
  input  logic captureDr,
  input  logic shiftDr,
  input  logic updateDr,
  input  logic selActive,
  input  logic cntOnStb,
  input  logic cntOffStb,
  input  logic tdi,
  input  logic portParked,
  output logic localTck,
  output logic tdo,
  output logic termStatus
);

  cntStrobes_t      strobes;
  logic             cntZero;
  logic             gateOff;
  logic [WIDTH-1:0] countQ;

  tck_cnt_ctrl u_ctrl (
    .tck        (tck),
    .rstN       (rstN),
    .tlrState   (tlrState),
    .captureDr  (captureDr),
    .shiftDr    (shiftDr),
    .updateDr   (updateDr),
    .selActive  (selActive),
    .cntOnStb   (cntOnStb),
    .cntOffStb  (cntOffStb),
    .portParked (portParked),
    .cntZero    (cntZero),
    .strobes    (strobes),
    .gateOff    (gateOff)
  );

  tck_cnt_datapath #(.WIDTH(WIDTH)) u_dp (
    .tck     (tck),
    .rstN    (rstN),
    .strobes (strobes),
    .tdi     (tdi),
    .tdo     (tdo),
    .cntZero (cntZero),
    .countQ  (countQ)
  );

  tck_cnt_clk_gate u_gate (
    .tck      (tck),
    .gateOff  (gateOff),
    .localTck (localTck)
  );

  assign termStatus = cntZero;

  // R6: an unparked port is never gated
  p_unparked_open_r6: assert property (@(posedge tck) disable iff (!rstN)
    !portParked |-> !gateOff);

  // R4: nonzero count always reports not done
  p_status_r4: assert property (@(posedge tck) disable iff (!rstN)
    (countQ != '0) |-> !termStatus);

endmodule

// File: tb/tck_cycle_counter_bench.sv
`timescale 1ns/1ps
module tck_cycle_counter_bench;

  localparam int W = 8;

  logic tck = 1'b0;
  logic rstN = 1'b0;
  logic tlrState = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0;
  logic selActive = 1'b0, cntOnStb = 1'b0, cntOffStb = 1'b0, tdi = 1'b0;
  logic portParked = 1'b1;
  logic localTck, tdo, termStatus;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [W-1:0] rb;

  always #4 tck = ~tck;

  tck_cycle_counter #(.WIDTH(W)) u_tck_cycle_counter (
    .tck(tck), .rstN(rstN), .tlrState(tlrState), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .selActive(selActive),
    .cntOnStb(cntOnStb), .cntOffStb(cntOffStb), .tdi(tdi),
    .portParked(portParked), .localTck(localTck), .tdo(tdo),
    .termStatus(termStatus)
  );

  always @(posedge localTck) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge tck);
  endtask

  // Shift a value in LSB first, then update; pulse count restarts at the update edge.
  task automatic scanLoad(input logic [W-1:0] v, input logic sel);
    selActive = sel;
    shiftDr = 1'b1;
    for (int i = 0; i < W; i++) begin
      tdi = v[i];
      tick();
    end
    shiftDr = 1'b0;
    updateDr = 1'b1;
    pulses = 0;
    tick();
    updateDr = 1'b0;
    selActive = 1'b0;
  endtask

  task automatic readBack(output logic [W-1:0] v);
    selActive = 1'b1;
    captureDr = 1'b1;
    tick();
    captureDr = 1'b0;
    shiftDr = 1'b1;
    tdi = 1'b0;
    for (int i = 0; i < W; i++) begin
      v[i] = tdo;
      tick();
    end
    shiftDr = 1'b0;
    selActive = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    // R1: reset state
    check("R1 status after reset", termStatus, 1);
    readBack(rb);
    check("R1 count after reset", rb, 0);

    // R5: disabled and parked at zero, clock passes ungated
    pulses = 0;
    tick(5);
    check("R5 ungated while off", pulses, 5);

    // R2: scan load and readback
    scanLoad(8'hA5, 1'b1);
    check("R4 status nonzero", termStatus, 0);
    pulses = 0;
    tick(6);
    check("R5 pulses while off", pulses, 6);
    readBack(rb);
    check("R2 readback", rb, 8'hA5);
    check("R5 count held while off", rb, 8'hA5);

    // R8: unselected scan has no effect
    scanLoad(8'h3C, 1'b0);
    readBack(rb);
    check("R8 unselected update ignored", rb, 8'hA5);

    // R7: Test-Logic-Reset clears count and switches counting off
    cntOnStb = 1'b1; tick(); cntOnStb = 1'b0;
    tlrState = 1'b1; tick(); tlrState = 1'b0;
    check("R7 status after clear", termStatus, 1);
    scanLoad(8'd3, 1'b1);
    pulses = 0;
    tick(6);
    check("R7 counting off after clear", pulses, 6);
    readBack(rb);
    check("R7 count not decremented", rb, 3);
    tlrState = 1'b1; tick(); tlrState = 1'b0;
    readBack(rb);
    check("R7 count cleared", rb, 0);

    // R5: off wins over simultaneous on
    cntOnStb = 1'b1; cntOffStb = 1'b1; tick(); cntOnStb = 1'b0; cntOffStb = 1'b0;
    scanLoad(8'd4, 1'b1);
    pulses = 0;
    tick(8);
    check("R5 off priority pulses", pulses, 8);
    readBack(rb);
    check("R5 off priority count", rb, 4);

    // R6: unparked port not gated at terminal count
    cntOnStb = 1'b1; tick(); cntOnStb = 1'b0;
    portParked = 1'b0;
    scanLoad(8'd2, 1'b1);
    pulses = 0;
    tick(10);
    check("R6 unparked ungated", pulses, 10);
    check("R4 status at zero", termStatus, 1);
    portParked = 1'b1;
    tick(2);

    // R9/R3: update edge gated, first pulse on the following edge
    scanLoad(8'd3, 1'b1);
    check("R9 no pulse on update edge", pulses, 0);
    tick();
    check("R3 first pulse after update", pulses, 1);
    tick(5);
    check("R3 total of three", pulses, 3);

    // R3/R4: sweep every load value
    for (int n = 0; n < (1 << W); n++) begin
      scanLoad(n[W-1:0], 1'b1);
      check("R4 status after load", termStatus, (n == 0) ? 1 : 0);
      tick(n + 3);
      check("R3 sweep pulse count", pulses, n);
      check("R4 status at end", termStatus, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule